// File: doc/BRIEF.md
# Bounded Euler-Stepped Memristance Emulator

This block models a two-terminal bipolar resistive switch in digital form. Each clock cycle may carry one voltage sample, given as a top-electrode value and a bottom-electrode value. The block takes their difference as the device voltage. From that voltage it forms a resistance slope. The slope grows slowly while the voltage stays inside a dead-band of symmetric half-width VTH. Outside that band it grows at a steeper rate.

The slope is scaled by a time step and added to the stored resistance, which is one forward Euler step. The time step is a power of two, chosen at run time as an arithmetic right shift. The result is held between a lower and an upper resistance limit. A load pulse restarts the model from a supplied starting resistance. The rate constants, the dead-band and the limits are elaboration-time parameters.

Top module: `memristance_euler`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `res_o` equals the parameter RRST.
- R2: A cycle with `init_i` high loads `rinit_i`, clipped to the range [RMIN, RMAX], into `res_o` on the next cycle. `init_i` wins over `sample_valid_i` in the same cycle.
- R3: `res_o` never leaves the range [RMIN, RMAX].
- R4: The device voltage is v = `vte_i` − `vbe_i`, both signed two's complement. For |v| ≤ VTH the slope is ALPHA·v, so v = 0 leaves the resistance unchanged.
- R5: For |v| > VTH the slope is BETA·v − (BETA−ALPHA)·VTH·sign(v). This is the same dead-band for both polarities. A positive v never lowers `res_o` and a negative v never raises it.
- R6: The Euler increment is the slope shifted right arithmetically by `dt_shift_i` places, which rounds toward minus infinity. For example, a slope of −6 with a shift of 2 gives −2, and with a shift of 15 gives −1.
- R7: Each cycle with `sample_valid_i` high and `init_i` low makes exactly one update, visible on `res_o` one cycle later. With neither input high, `res_o` holds.
- R8: An update that would pass RMAX or RMIN leaves `res_o` exactly at that limit instead of being discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Load starting resistance this cycle |
| rinit_i | input | RW | Starting resistance, unsigned |
| sample_valid_i | input | 1 | A voltage sample is present this cycle |
| vte_i | input | VW | Top-electrode voltage, signed |
| vbe_i | input | VW | Bottom-electrode voltage, signed |
| dt_shift_i | input | SW | Time step as a right-shift count |
| res_o | output | RW | Present memristance, unsigned |

## Verification
The bench overrides the parameters with ALPHA=2, BETA=16, VTH=64 and limits of 1000 to 5000, with a reset value of 3000. With a band that narrow, a few single samples reach both limits. The voltage points at VTH and at VTH+1 show the knee of the slope. Slopes of −6 and −15104 under several shift counts make the floor rounding visible. The zero-voltage and no-sample cycles check that nothing moves when no update should happen.

// File: rtl/memr_pkg.sv
package memr_pkg;
  localparam int CALC_W = 32;
  typedef logic signed [CALC_W-1:0] calc_t;

  function automatic calc_t mag(input calc_t x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic calc_t bound(input calc_t x, input calc_t lo, input calc_t hi);
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction
endpackage

// File: rtl/memr_drive.sv
module memr_drive
  import memr_pkg::*;
#(
  parameter int VW = 12
) (
  input  logic signed [VW-1:0] top_i,
  input  logic signed [VW-1:0] bot_i,
  output calc_t                v_o
);
  // device voltage: plain difference, sign-extended into the calc width
  assign v_o = calc_t'(top_i) - calc_t'(bot_i);
endmodule

// File: rtl/memr_slope.sv
module memr_slope
  import memr_pkg::*;
#(
  parameter int ALPHA = 1,
  parameter int BETA  = 20,
  parameter int VTH   = 100
) (
  input  calc_t v_i,
  output calc_t d_o
);
  localparam calc_t KA = calc_t'(ALPHA);
  localparam calc_t KB = calc_t'(BETA);
  localparam calc_t KT = calc_t'(VTH);

  // dR/dt from the absolute-value form; the bracket is always even
  function automatic calc_t slope(input calc_t v);
    calc_t bend;
    bend = mag(v + KT) - mag(v - KT);
    return KB * v + (((KA - KB) * bend) >>> 1);
  endfunction

  assign d_o = slope(v_i);
endmodule

// File: rtl/memr_integrator.sv
module memr_integrator
  import memr_pkg::*;
#(
  parameter int RW   = 16,
  parameter int SW   = 4,
  parameter int RMIN = 1000,
  parameter int RMAX = 60000,
  parameter int RRST = 30000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic [RW-1:0] rinit_i,
  input  logic          sample_valid_i,
  input  logic [SW-1:0] dt_shift_i,
  input  calc_t         d_i,
  output logic [RW-1:0] r_o,
  output logic          step_en_o,
  output logic          clip_hi_o,
  output logic          clip_lo_o
);
  localparam calc_t LO  = calc_t'(RMIN);
  localparam calc_t HI  = calc_t'(RMAX);
  localparam int    PAD = CALC_W - RW;

  logic [RW-1:0] r_q;
  logic [RW-1:0] r_nxt;
  calc_t         r_ext;
  calc_t         load_ext;
  calc_t         inc;
  calc_t         sum;

  function automatic logic [RW-1:0] to_res(input calc_t x);
    calc_t c;
    c = bound(x, LO, HI);
    return c[RW-1:0];
  endfunction

  assign r_ext     = calc_t'({{PAD{1'b0}}, r_q});
  assign load_ext  = calc_t'({{PAD{1'b0}}, rinit_i});
  assign inc       = d_i >>> dt_shift_i;   // dt = 2^-shift, floor rounding
  assign sum       = r_ext + inc;
  assign step_en_o = sample_valid_i && !init_i;
  assign clip_hi_o = step_en_o && (sum > HI);
  assign clip_lo_o = step_en_o && (sum < LO);

  always_comb begin
    r_nxt = r_q;
    if (init_i)         r_nxt = to_res(load_ext);
    else if (step_en_o) r_nxt = to_res(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_q <= RW'(RRST);
    else        r_q <= r_nxt;
  end

  assign r_o = r_q;
endmodule

// File: rtl/memristance_euler.sv
module memristance_euler
  import memr_pkg::*;
#(
  parameter int VW    = 12,
  parameter int RW    = 16,
  parameter int SW    = 4,
  parameter int ALPHA = 1,
  parameter int BETA  = 20,
  parameter int VTH   = 100,
  parameter int RMIN  = 1000,
  parameter int RMAX  = 60000,
  parameter int RRST  = 30000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init_i,
  input  logic [RW-1:0]        rinit_i,
  input  logic                 sample_valid_i,
  input  logic signed [VW-1:0] vte_i,
  input  logic signed [VW-1:0] vbe_i,
  input  logic [SW-1:0]        dt_shift_i,
  output logic [RW-1:0]        res_o
);
  calc_t v_w;
  calc_t d_w;
  logic  step_en_w;
  logic  clip_hi_w;
  logic  clip_lo_w;

  memr_drive #(.VW(VW)) drive_i (
    .top_i(vte_i),
    .bot_i(vbe_i),
    .v_o  (v_w)
  );

  memr_slope #(.ALPHA(ALPHA), .BETA(BETA), .VTH(VTH)) slope_i (
    .v_i(v_w),
    .d_o(d_w)
  );

  memr_integrator #(
    .RW(RW), .SW(SW), .RMIN(RMIN), .RMAX(RMAX), .RRST(RRST)
  ) integ_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .init_i        (init_i),
    .rinit_i       (rinit_i),
    .sample_valid_i(sample_valid_i),
    .dt_shift_i    (dt_shift_i),
    .d_i           (d_w),
    .r_o           (res_o),
    .step_en_o     (step_en_w),
    .clip_hi_o     (clip_hi_w),
    .clip_lo_o     (clip_lo_w)
  );
endmodule

// File: rtl/memristance_euler_chk.sv
module memristance_euler_chk #(
  parameter int VW   = 12,
  parameter int RW   = 16,
  parameter int RMIN = 1000,
  parameter int RMAX = 60000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 init_i,
  input logic                 sample_valid_i,
  input logic signed [VW-1:0] vte_i,
  input logic signed [VW-1:0] vbe_i,
  input logic [RW-1:0]        res_o,
  input logic                 step_en,
  input logic                 clip_hi,
  input logic                 clip_lo
);
  localparam logic [RW-1:0] LO = RW'(RMIN);
  localparam logic [RW-1:0] HI = RW'(RMAX);

  p_in_bounds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_o >= LO) && (res_o <= HI));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !sample_valid_i) |=> $stable(res_o));

  p_zero_v_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && (vte_i == vbe_i)) |=> $stable(res_o));

  p_pos_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && (vte_i > vbe_i)) |=> (res_o >= $past(res_o)));

  p_neg_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && (vte_i < vbe_i)) |=> (res_o <= $past(res_o)));

  p_clip_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clip_hi |=> (res_o == HI));

  p_clip_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clip_lo |=> (res_o == LO));
endmodule

bind memristance_euler memristance_euler_chk #(
  .VW(VW), .RW(RW), .RMIN(RMIN), .RMAX(RMAX)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .init_i        (init_i),
  .sample_valid_i(sample_valid_i),
  .vte_i         (vte_i),
  .vbe_i         (vbe_i),
  .res_o         (res_o),
  .step_en       (step_en_w),
  .clip_hi       (clip_hi_w),
  .clip_lo       (clip_lo_w)
);

// File: tb/memristance_euler_tb_top.sv
module memristance_euler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 12, RW = 16, SW = 4;
  localparam int ALPHA = 2, BETA = 16, VTH = 64;
  localparam int RMIN = 1000, RMAX = 5000, RRST = 3000;
  localparam int NVEC = 15;
  // columns: vte, vbe, shift, expected resistance after the step
  localparam int VEC [NVEC][4] = '{
    '{   50,   0, 0, 3100},
    '{    0,  50, 1, 3050},
    '{  300, 200, 0, 3754},
    '{ -100,   0, 2, 3578},
    '{    7,   0, 0, 3592},
    '{   -3,   0, 1, 3589},
    '{   -3,   0, 2, 3587},
    '{   64,   0, 0, 3715},
    '{   65,   0, 0, 3859},
    '{    0,   0, 0, 3859},
    '{ 1000,   0, 0, 5000},
    '{-1000,   0, 3, 3112},
    '{-2000,   0, 0, 1000},
    '{  -50,   0, 0, 1000},
    '{   20,   0, 0, 1040}
  };

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 init_i = 1'b0;
  logic [RW-1:0]        rinit_i = '0;
  logic                 sample_valid_i = 1'b0;
  logic signed [VW-1:0] vte_i = '0;
  logic signed [VW-1:0] vbe_i = '0;
  logic [SW-1:0]        dt_shift_i = '0;
  logic [RW-1:0]        res_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memristance_euler #(
    .VW(VW), .RW(RW), .SW(SW), .ALPHA(ALPHA), .BETA(BETA), .VTH(VTH),
    .RMIN(RMIN), .RMAX(RMAX), .RRST(RRST)
  ) dut_i (.*);

  task automatic check(input string req, input int expv);
    checks++;
    if (int'(res_o) != expv) begin
      errors++;
      $display("FAIL %s res_o actual %0d expected %0d", req, res_o, expv);
    end
  endtask

  task automatic sample(input int vt, input int vb, input int sh);
    sample_valid_i = 1'b1;
    vte_i = VW'(vt);
    vbe_i = VW'(vb);
    dt_shift_i = SW'(sh);
    @(posedge clk);
    @(negedge clk);
    sample_valid_i = 1'b0;
  endtask

  task automatic load(input int r);
    init_i = 1'b1;
    rinit_i = RW'(r);
    @(posedge clk);
    @(negedge clk);
    init_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 during reset", RRST);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", RRST);

    // table walk: R4 R5 R6 R8 along one trajectory
    for (int i = 0; i < NVEC; i++) begin
      sample(VEC[i][0], VEC[i][1], VEC[i][2]);
      check($sformatf("R4/R5/R6/R8 vector %0d", i), VEC[i][3]);
    end

    // R7: voltage present but no valid strobe leaves res_o alone
    vte_i = 12'sd900;
    repeat (3) @(negedge clk);
    check("R7 hold without sample", 1040);

    // R2: plain load, then clipped loads above and below
    load(2500);
    check("R2 load", 2500);
    load(6000);
    check("R2 load clipped high", RMAX);
    load(10);
    check("R2 load clipped low", RMIN);

    // R2: load wins over a simultaneous sample
    init_i = 1'b1;
    rinit_i = RW'(2000);
    sample(1000, 0, 0);
    init_i = 1'b0;
    check("R2 init priority", 2000);

    // R6: largest shift, floor rounding on both signs
    sample(7, 0, 15);
    check("R6 positive shifted to zero", 2000);
    sample(-3, 0, 15);
    check("R6 negative floors to -1", 1999);

    // R5: symmetric knee on the negative side (slope -128 at -VTH, -144 at -VTH-1)
    sample(-64, 0, 0);
    check("R5 at minus threshold", 1871);
    sample(0, 65, 0);
    check("R5 beyond minus threshold", 1727);

    // R7: two back-to-back samples give two updates
    sample(10, 0, 0);
    sample(10, 0, 0);
    check("R7 one update per sample", 1767);

    // R3/R8: exactly reaching the upper limit is allowed
    load(4900);
    sample(50, 0, 0);
    check("R8 land on limit", RMAX);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule